// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block keeps the running address and the row and column counters of one DMA channel. Each time the data path reports that one element has moved, the block advances the address by a signed 16-bit column stride and counts the column down. When a row runs out, the block can raise a single interrupt pulse. It then takes one of three actions. It starts the next row in two-dimensional mode, it stops the channel, or it asks for the next descriptor. The bus transfer is handled elsewhere.

A start strobe loads the parameters and sets the channel running. While a descriptor request is outstanding, the block waits. A reload acknowledge then loads a fresh parameter set from the same inputs, and stepping continues. A count loaded as zero stands for the largest count. The block flags a column stride whose magnitude differs from the element size.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, run, interrupt, done, reload request and configuration error are all low, and the address and both counts are zero.
- R2: A start strobe loads the start address and both counts into the current registers and sets run, all visible in the cycle after the strobe. A start strobe has priority over a reload acknowledge and over an element strobe in the same cycle.
- R3: A count input of zero loads as 65535, for both the column count and the row count, at start and at reload.
- R4: An accepted element strobe that is not the last of its row adds the sign-extended column stride to the address, modulo 2^32. It also decrements the column count by one.
- R5: The last element of a row produces one interrupt pulse exactly when the interrupt enable was set at load time.
- R6: In two-dimensional mode with a row count above 1, the last element of a row does not apply the column stride. Instead it adds the sign-extended row stride to the address, reloads the column count with its loaded value and decrements the row count.
- R7: When no row remains and flow mode is 0 (stop), the address takes its final column step, the column count becomes 0, run clears and done pulses for one cycle.
- R8: When no row remains and flow mode is nonzero, the address takes its final column step and the column count becomes 0. The reload request then rises and stays high until a reload acknowledge, which loads new parameters, drops the request and keeps run high.
- R9: Element strobes are ignored while run is low or a reload request is pending.
- R10: The configuration error output is high after a load whose column stride magnitude differs from the element size. The element size code is 1 for 2 bytes, 2 for 4 bytes, and 0 or 3 for 1 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load parameters and start the channel |
| reload_ack_i | input | 1 | Next descriptor is on the parameter inputs |
| elem_done_i | input | 1 | One element transferred |
| start_addr_i | input | 32 | Start address |
| x_count_i | input | 16 | Elements per row (0 means 65535) |
| x_mod_i | input | 16 | Signed column stride in bytes |
| y_count_i | input | 16 | Rows (0 means 65535) |
| y_mod_i | input | 16 | Signed row stride in bytes |
| mode_2d_i | input | 1 | Two-dimensional mode enable |
| irq_en_i | input | 1 | Row-end interrupt enable |
| flow_i | input | 3 | Flow mode; 0 stops, others chain |
| elem_size_i | input | 2 | Element size code |
| curr_addr_o | output | 32 | Current address |
| curr_x_o | output | 16 | Current column count |
| curr_y_o | output | 16 | Current row count |
| run_o | output | 1 | Channel running |
| irq_o | output | 1 | Row-end interrupt pulse |
| done_o | output | 1 | Completion pulse |
| reload_req_o | output | 1 | Descriptor reload requested |
| cfg_err_o | output | 1 | Column stride does not match element size |

## Verification
The bench targets row changes in two-dimensional mode. A design that also applied the column stride there would end each row one stride off. Negative strides that cross address zero expose missing sign extension or wrap handling. Strobes sent while a reload is pending or after completion would move the address if the gating were lost. Zero counts would end the row at once, or underflow, if they were not widened to the maximum.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ACT_STEP   = 2'd0,
    ACT_ROW    = 2'd1,
    ACT_FINISH = 2'd2,
    ACT_CHAIN  = 2'd3
  } row_act_e;

  localparam logic [2:0] FLOW_STOP = 3'd0;
endpackage

// File: rtl/dma2d_load_conv.sv
module dma2d_load_conv #(
  parameter int CNT_W = 16,
  parameter int MOD_W = 16
) (
  input  logic [CNT_W-1:0] x_count_i,
  input  logic [CNT_W-1:0] y_count_i,
  input  logic [MOD_W-1:0] x_mod_i,
  input  logic [1:0]       elem_size_i,
  output logic [CNT_W-1:0] x_eff_o,
  output logic [CNT_W-1:0] y_eff_o,
  output logic             cfg_err_o
);
  logic [1:0][CNT_W-1:0] cnt_in, cnt_out;
  assign cnt_in = {y_count_i, x_count_i};

  // zero count stands for the maximum
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    assign cnt_out[g] = (cnt_in[g] == '0) ? {CNT_W{1'b1}} : cnt_in[g];
  end
  assign x_eff_o = cnt_out[0];
  assign y_eff_o = cnt_out[1];

  logic [MOD_W-1:0] mag, size_b;
  always_comb begin
    mag = x_mod_i[MOD_W-1] ? (~x_mod_i + 1'b1) : x_mod_i;
    unique case (elem_size_i)
      2'd1:    size_b = MOD_W'(2);
      2'd2:    size_b = MOD_W'(4);
      default: size_b = MOD_W'(1);
    endcase
  end
  assign cfg_err_o = (mag != size_b);
endmodule

// File: rtl/dma2d_row_ctrl.sv
module dma2d_row_ctrl
  import dma2d_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] x_cnt_i,
  input  logic [CNT_W-1:0] y_cnt_i,
  input  logic             mode_2d_i,
  input  logic [2:0]       flow_i,
  output row_act_e         act_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    if (x_cnt_i > ONE)                     act_o = ACT_STEP;
    else if (mode_2d_i && (y_cnt_i > ONE)) act_o = ACT_ROW;
    else if (flow_i == FLOW_STOP)          act_o = ACT_FINISH;
    else                                   act_o = ACT_CHAIN;
  end
endmodule

// File: rtl/dma2d_addr_add.sv
module dma2d_addr_add #(
  parameter int ADDR_W = 32,
  parameter int MOD_W  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic [ADDR_W-1:0] sum_o
);
  logic [ADDR_W-1:0] mod_ext;

  if (ADDR_W > MOD_W) begin : g_ext
    assign mod_ext = {{(ADDR_W-MOD_W){mod_i[MOD_W-1]}}, mod_i};
  end else begin : g_trunc
    assign mod_ext = mod_i[ADDR_W-1:0];
  end

  assign sum_o = addr_i + mod_ext;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              reload_ack_i,
  input  logic              elem_done_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  x_count_i,
  input  logic [MOD_W-1:0]  x_mod_i,
  input  logic [CNT_W-1:0]  y_count_i,
  input  logic [MOD_W-1:0]  y_mod_i,
  input  logic              mode_2d_i,
  input  logic              irq_en_i,
  input  logic [2:0]        flow_i,
  input  logic [1:0]        elem_size_i,
  output logic [ADDR_W-1:0] curr_addr_o,
  output logic [CNT_W-1:0]  curr_x_o,
  output logic [CNT_W-1:0]  curr_y_o,
  output logic              run_o,
  output logic              irq_o,
  output logic              done_o,
  output logic              reload_req_o,
  output logic              cfg_err_o
);
  logic [ADDR_W-1:0] addr_q, addr_sum;
  logic [CNT_W-1:0]  x_q, y_q, xcnt_p;
  logic [MOD_W-1:0]  xmod_p, ymod_p, mod_sel;
  logic              mode2d_p, irqen_p;
  logic [2:0]        flow_p;
  logic              run_q, pend_q, irq_q, done_q, err_q;

  logic [CNT_W-1:0]  x_eff, y_eff;
  logic              err_new;
  row_act_e          act;
  logic              load, advance;

  dma2d_load_conv #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_conv (
    .x_count_i  (x_count_i),
    .y_count_i  (y_count_i),
    .x_mod_i    (x_mod_i),
    .elem_size_i(elem_size_i),
    .x_eff_o    (x_eff),
    .y_eff_o    (y_eff),
    .cfg_err_o  (err_new)
  );

  dma2d_row_ctrl #(.CNT_W(CNT_W)) u_row (
    .x_cnt_i  (x_q),
    .y_cnt_i  (y_q),
    .mode_2d_i(mode2d_p),
    .flow_i   (flow_p),
    .act_o    (act)
  );

  // row change replaces the final column step with the row stride
  assign mod_sel = (act == ACT_ROW) ? ymod_p : xmod_p;

  dma2d_addr_add #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_add (
    .addr_i(addr_q),
    .mod_i (mod_sel),
    .sum_o (addr_sum)
  );

  assign load    = start_i || (pend_q && reload_ack_i);
  assign advance = elem_done_i && run_q && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      x_q      <= '0;
      y_q      <= '0;
      xcnt_p   <= '0;
      xmod_p   <= '0;
      ymod_p   <= '0;
      mode2d_p <= 1'b0;
      irqen_p  <= 1'b0;
      flow_p   <= '0;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      if (load) begin
        addr_q   <= start_addr_i;
        x_q      <= x_eff;
        y_q      <= y_eff;
        xcnt_p   <= x_eff;
        xmod_p   <= x_mod_i;
        ymod_p   <= y_mod_i;
        mode2d_p <= mode_2d_i;
        irqen_p  <= irq_en_i;
        flow_p   <= flow_i;
        err_q    <= err_new;
        pend_q   <= 1'b0;
        if (start_i) run_q <= 1'b1;
      end else if (advance) begin
        addr_q <= addr_sum;
        unique case (act)
          ACT_STEP: x_q <= x_q - 1'b1;
          ACT_ROW: begin
            irq_q <= irqen_p;
            x_q   <= xcnt_p;
            y_q   <= y_q - 1'b1;
          end
          ACT_FINISH: begin
            irq_q  <= irqen_p;
            x_q    <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
          default: begin
            irq_q  <= irqen_p;
            x_q    <= '0;
            pend_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign curr_addr_o  = addr_q;
  assign curr_x_o     = x_q;
  assign curr_y_o     = y_q;
  assign run_o        = run_q;
  assign irq_o        = irq_q;
  assign done_o       = done_q;
  assign reload_req_o = pend_q;
  assign cfg_err_o    = err_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              reload_ack_i,
  input logic              elem_done_i,
  input logic [ADDR_W-1:0] curr_addr_o,
  input logic [CNT_W-1:0]  curr_x_o,
  input logic              run_o,
  input logic              irq_o,
  input logic              done_o,
  input logic              reload_req_o
);
  assert_no_zero_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !reload_req_o) |-> (curr_x_o != '0));

  assert_col_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !reload_req_o && elem_done_i && !start_i && (curr_x_o > CNT_W'(1)))
      |=> (curr_x_o == $past(curr_x_o) - 1'b1));

  assert_irq_after_elem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(elem_done_i));

  assert_done_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_req_o && !reload_ack_i && !start_i) |=> reload_req_o);

  assert_ignore_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!run_o || reload_req_o) && !start_i && !reload_ack_i)
      |=> ($stable(curr_addr_o) && $stable(curr_x_o)));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start, ack, elem, m2d, ien;
  logic [31:0] sa;
  logic [15:0] xc, xm, yc, ym;
  logic [2:0]  flow;
  logic [1:0]  es;
  logic [31:0] addr_o;
  logic [15:0] x_o, y_o;
  logic        run_o, irq_o, done_o, req_o, err_o;

  dma2d_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reload_ack_i(ack),
    .elem_done_i(elem), .start_addr_i(sa), .x_count_i(xc), .x_mod_i(xm),
    .y_count_i(yc), .y_mod_i(ym), .mode_2d_i(m2d), .irq_en_i(ien),
    .flow_i(flow), .elem_size_i(es), .curr_addr_o(addr_o), .curr_x_o(x_o),
    .curr_y_o(y_o), .run_o(run_o), .irq_o(irq_o), .done_o(done_o),
    .reload_req_o(req_o), .cfg_err_o(err_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0] m_addr;
  int m_x, m_y, p_x, p_xm, p_ym, p_flow;
  bit m_run, m_pend, m_irq, m_done, m_err, p_2d, p_ien;

  function automatic int size_of(logic [1:0] c);
    return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
  endfunction

  function automatic void m_load();
    int a;
    m_addr = sa;
    m_x = (xc == 0) ? 65535 : int'(xc);
    m_y = (yc == 0) ? 65535 : int'(yc);
    p_x = m_x;
    p_xm = int'($signed(xm));
    p_ym = int'($signed(ym));
    p_2d = m2d; p_ien = ien; p_flow = int'(flow);
    a = (p_xm < 0) ? -p_xm : p_xm;
    m_err = (a != size_of(es));
    m_pend = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_x = 0; m_y = 0; m_run = 0; m_pend = 0;
      m_irq = 0; m_done = 0; m_err = 0;
    end else begin
      m_irq = 0; m_done = 0;
      if (start) begin
        m_load(); m_run = 1;
      end else if (m_pend && ack) begin
        m_load();
      end else if (elem && m_run && !m_pend) begin
        if (m_x > 1) begin
          m_addr = m_addr + 32'(p_xm); m_x--;
        end else begin
          m_irq = p_ien;
          if (p_2d && m_y > 1) begin
            m_addr = m_addr + 32'(p_ym); m_y--; m_x = p_x;
          end else begin
            m_addr = m_addr + 32'(p_xm); m_x = 0;
            if (p_flow == 0) begin m_run = 0; m_done = 1; end
            else m_pend = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    check("R4 addr", addr_o, m_addr);
    check("R4 xcount", x_o, m_x);
    check("R6 ycount", y_o, m_y);
    check("R7 run", run_o, m_run);
    check("R5 irq", irq_o, m_irq);
    check("R7 done", done_o, m_done);
    check("R8 reload_req", req_o, m_pend);
    check("R10 cfg_err", err_o, m_err);
  end

  task automatic set_par(logic [31:0] a, logic [15:0] xcv, logic [15:0] xmv,
                         logic [15:0] ycv, logic [15:0] ymv, bit d2, bit ie,
                         logic [2:0] fl, logic [1:0] esv);
    sa = a; xc = xcv; xm = xmv; yc = ycv; ym = ymv;
    m2d = d2; ien = ie; flow = fl; es = esv;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic strobes(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); elem = 1;
      @(negedge clk); elem = 0;
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold_a;
    start = 0; ack = 0; elem = 0;
    set_par(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 run", run_o, 0);
    check("R1 addr", addr_o, 0);
    check("R1 flags", {irq_o, done_o, req_o, err_o}, 0);

    // R9 strobes before start are ignored
    strobes(2, 0);
    check("R9 idle addr", addr_o, 0);

    // 1D, 4-byte elements, stop with interrupt
    set_par(32'h1000, 4, 16'd4, 1, 0, 0, 1, 0, 2);
    pulse_start();
    check("R2 start addr", addr_o, 32'h1000);
    check("R2 start x", x_o, 4);
    check("R2 run", run_o, 1);
    strobes(4, 0);
    check("R7 final addr", addr_o, 32'h1010);
    check("R7 stopped", run_o, 0);

    // R9 strobes after completion are ignored
    strobes(3, 1);
    check("R9 after done", addr_o, 32'h1010);

    // negative stride wraps through zero, 2-byte elements
    set_par(32'h2, 3, 16'hFFFE, 1, 0, 0, 0, 0, 1);
    pulse_start();
    strobes(3, 1);
    check("R4 wrap addr", addr_o, 32'hFFFF_FFFC);

    // 2D with row stride, irq on each row
    set_par(32'h100, 3, 16'd1, 3, 16'd10, 1, 1, 0, 0);
    pulse_start();
    strobes(3, 0);
    check("R6 row addr", addr_o, 32'h10C);
    check("R6 row x", x_o, 3);
    check("R6 row y", y_o, 2);
    strobes(6, 1);

    // 2D with negative row stride
    set_par(32'h8000, 2, 16'd2, 2, 16'hFFF0, 1, 0, 0, 1);
    pulse_start();
    strobes(4, 1);

    // chaining flow, pending request, ignored strobes, reload
    set_par(32'h4000, 2, 16'd4, 1, 0, 0, 1, 3'd3, 2);
    pulse_start();
    strobes(2, 0);
    check("R8 req", req_o, 1);
    hold_a = addr_o;
    strobes(3, 0);
    check("R9 pending addr", addr_o, hold_a);
    set_par(32'h5000, 0, 16'hFFFF, 0, 0, 1, 0, 3'd0, 0);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    check("R8 reloaded addr", addr_o, 32'h5000);
    check("R3 zero x", x_o, 65535);
    check("R3 zero y", y_o, 65535);
    check("R8 run kept", run_o, 1);
    strobes(20, 1);

    // ack with no pending request does nothing
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    check("R8 stray ack", addr_o, 32'h5000 - 20);

    // R10 stride mismatch and match
    set_par(32'h0, 2, 16'd3, 1, 0, 0, 0, 0, 0);
    pulse_start();
    check("R10 mismatch", err_o, 1);
    set_par(32'h0, 2, 16'hFFFC, 1, 0, 0, 0, 0, 2);
    pulse_start();
    check("R10 match", err_o, 0);

    // start wins over a simultaneous element strobe
    set_par(32'h7000, 5, 16'd1, 1, 0, 0, 0, 0, 0);
    @(negedge clk); start = 1; elem = 1;
    @(negedge clk); start = 0; elem = 0;
    check("R2 priority", addr_o, 32'h7000);
    strobes(5, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule